// File: doc/BRIEF.md
# Receive Byte Queue with Word-Packed Read Port

This block sits between an I2C transfer engine and the register file of its controller. The engine pushes received bytes one at a time. Software drains them through a 32-bit data register. Each read of that register takes up to four bytes from the head of the queue and packs them little-endian: the oldest byte goes in the lowest lane. Lanes without a byte read as zero.

A status byte reports how full the queue is as a rounded-up count of 32-bit words, next to a fixed free-slot code. A flush command empties the queue. Three signals go to an interrupt block: an underflow event for a read of an empty queue, a data-request event that stays up while received data is waiting, and a one-cycle request to the transfer engine to fetch more bytes while a read transfer is still open.

The queue holds 32 bytes by default. A byte pushed into a full queue is dropped and noted in a sticky overflow flag. The push path, the pop path and the reset are synchronous, and reset is active high.

Top module: `rx_word_packer`

## Requirements
- R1: After reset the queue is empty, `fifo_status` reads 8'h80, `rd_data` reads zero, and `evt_underflow`, `evt_data_req`, `more_req` and `overflow_seen` are low.
- R2: A read (`rd_strobe` high for one cycle) of an empty queue shows `rd_data` = 0 in that cycle and raises `evt_underflow` from the next cycle. The flag stays up until a flush or a reset.
- R3: A read of a non-empty queue removes min(count,4) bytes. The oldest byte appears on bits 7:0, the next on 15:8, then 23:16 and 31:24. Lanes beyond the bytes removed read zero.
- R4: Every accepted push sets `evt_data_req` from the next cycle.
- R5: `evt_data_req` clears when a read leaves the queue empty and no byte is accepted in the same cycle. A read that leaves bytes behind does not clear it.
- R6: `fifo_status[3:0]` equals ceil(count/4). `fifo_status[7:4]` is always 4'h8.
- R7: `flush` empties the queue and clears `evt_underflow` from the next cycle. A push in the same cycle is dropped. `evt_data_req` is left unchanged.
- R8: `more_req` is high for exactly the one cycle after a read that removed at least one byte while `xfer_open` was high. An empty read, or a read with `xfer_open` low, gives no pulse.
- R9: A push into a full queue with no read in the same cycle is dropped and sets `overflow_seen`, which stays high until reset. A push in the same cycle as a read of a full queue is accepted.
- R10: Asserting `rst` in the middle of operation empties the queue and clears all flags at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Byte offered by the transfer engine |
| push_byte | input | 8 | Received byte |
| rd_strobe | input | 1 | Data register read; removes bytes at the clock edge |
| rd_data | output | 32 | Packed word; valid while `rd_strobe` is high |
| fifo_status | output | 8 | {4'h8, ceil(count/4)} |
| flush | input | 1 | Empties the queue and clears underflow |
| xfer_open | input | 1 | Current read transfer still owes bytes |
| more_req | output | 1 | One-cycle request to the engine for more bytes |
| evt_underflow | output | 1 | Empty-read event (interrupt bit 4) |
| evt_data_req | output | 1 | Data-waiting event (interrupt bit 0) |
| overflow_seen | output | 1 | Sticky: a push was dropped on a full queue |

## Verification
The read path is driven with byte counts of 1, 2, 3, 4 and more than 4 waiting. These show whether the lane order, the zeroing of empty lanes and the per-read byte count are right. Empty reads are checked against reads that leave data behind and reads that drain the queue, which separates the underflow rule from the data-request clear. A full queue is pushed alone and then together with a read, which tells a dropped byte from an accepted one. The status byte is checked at counts on and between word boundaries, which exposes a rounding error.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned WORD_LANES = 4;
    localparam int unsigned WORD_W     = BYTE_W * WORD_LANES;
    localparam int unsigned POP_W      = $clog2(WORD_LANES + 1);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [POP_W-1:0]  pop_t;

    // Status byte: upper nibble fixed free-slot code, lower nibble word count
    typedef struct packed {
        logic [3:0] free_code;
        logic [3:0] words;
    } fifo_stat_t;

    // Event/flag bundle carried from the event tracker to the top
    typedef struct packed {
        logic underflow;
        logic data_req;
        logic overflow;
        logic more_req;
    } evt_t;

    function automatic logic [3:0] words_of(input int unsigned n_bytes);
        return 4'((n_bytes + WORD_LANES - 1) / WORD_LANES);
    endfunction

    function automatic int unsigned min_lanes(input int unsigned n_bytes);
        return (n_bytes >= WORD_LANES) ? WORD_LANES : n_bytes;
    endfunction

endpackage

// File: rtl/rxp_byte_ring.sv
module rxp_byte_ring
    import rxp_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned PW   = $clog2(DEPTH),
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     wr_en,
    input  byte_t                    wr_byte,
    input  pop_t                     pop_n,
    output logic [CW-1:0]            count,
    output byte_t [WORD_LANES-1:0]   peek
);

    byte_t          mem [DEPTH];
    logic [PW-1:0]  rd_ptr;
    logic [PW-1:0]  wr_ptr;

    // Storage without reset: contents are only meaningful below count
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= wr_ptr + PW'(1);
            end
            rd_ptr <= rd_ptr + PW'(pop_n);
            count  <= count + CW'(wr_en) - CW'(pop_n);
        end
    end

    // Head window: the next WORD_LANES bytes, wrapping on the power-of-two depth
    for (genvar i = 0; i < WORD_LANES; i++) begin : g_peek
        logic [PW-1:0] idx;
        assign idx     = rd_ptr + PW'(i);
        assign peek[i] = mem[idx];
    end

    p_count_bounded_r9: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    p_flush_empties_r7: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

    p_no_overpop_r3: assert property (@(posedge clk) disable iff (rst)
        CW'(pop_n) <= count);

endmodule

// File: rtl/rxp_packer.sv
module rxp_packer
    import rxp_pkg::*;
#(
    parameter int unsigned CW = 6
) (
    input  logic                     rd_req,
    input  logic [CW-1:0]            count,
    input  byte_t [WORD_LANES-1:0]   peek,
    output pop_t                     pop_n,
    output word_t                    word
);

    pop_t avail;

    always_comb begin
        avail = pop_t'(min_lanes(int'(count)));
        pop_n = rd_req ? avail : '0;
    end

    // Little-endian lane placement; lanes past the available bytes are zero
    for (genvar i = 0; i < WORD_LANES; i++) begin : g_lane
        assign word[i*BYTE_W +: BYTE_W] = (pop_t'(i) < avail) ? peek[i] : '0;
    end

endmodule

// File: rtl/rxp_events.sv
module rxp_events
    import rxp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  push_req,
    input  logic  push_ok,
    input  logic  rd_req,
    input  logic  empty_now,
    input  logic  empty_next,
    input  pop_t  pop_n,
    input  logic  xfer_open,
    output evt_t  evt
);

    logic popped;
    assign popped = (pop_n != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            evt <= '0;
        end else begin
            // underflow: flush clears and wins over a same-cycle empty read
            if (flush) begin
                evt.underflow <= 1'b0;
            end else if (rd_req && empty_now) begin
                evt.underflow <= 1'b1;
            end

            // data request: any accepted byte sets it; draining read clears it
            if (push_ok) begin
                evt.data_req <= 1'b1;
            end else if (popped && empty_next) begin
                evt.data_req <= 1'b0;
            end

            if (push_req && !push_ok && !flush) begin
                evt.overflow <= 1'b1;
            end

            evt.more_req <= popped && xfer_open;
        end
    end

    p_underflow_set_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_req && empty_now && !flush) |=> evt.underflow);

    p_dreq_on_push_r4: assert property (@(posedge clk) disable iff (rst)
        push_ok |=> evt.data_req);

    p_more_req_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(evt.more_req) |-> $past(rd_req && xfer_open));

    p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        evt.overflow |=> evt.overflow);

endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer
    import rxp_pkg::*;
#(
    parameter int unsigned DEPTH     = 32,
    parameter int unsigned FREE_CODE = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push_valid,
    input  logic [7:0]  push_byte,
    input  logic        rd_strobe,
    output logic [31:0] rd_data,
    output logic [7:0]  fifo_status,
    input  logic        flush,
    input  logic        xfer_open,
    output logic        more_req,
    output logic        evt_underflow,
    output logic        evt_data_req,
    output logic        overflow_seen
);

    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0]           count;
    byte_t [WORD_LANES-1:0]  peek;
    pop_t                    pop_n;
    word_t                   word;
    logic                    push_ok;
    logic                    empty_now;
    logic                    empty_next;
    fifo_stat_t              stat;
    evt_t                    evt;

    // Accept a byte unless flushing, or full with no read freeing space
    always_comb begin
        push_ok    = push_valid && !flush && ((count < CW'(DEPTH)) || (pop_n != '0));
        empty_now  = (count == '0);
        empty_next = ((count - CW'(pop_n) + CW'(push_ok)) == '0);
        stat.free_code = 4'(FREE_CODE);
        stat.words     = words_of(int'(count));
    end

    rxp_byte_ring #(.DEPTH(DEPTH)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .wr_en   (push_ok),
        .wr_byte (push_byte),
        .pop_n   (pop_n),
        .count   (count),
        .peek    (peek)
    );

    rxp_packer #(.CW(CW)) u_pack (
        .rd_req (rd_strobe && !flush),
        .count  (count),
        .peek   (peek),
        .pop_n  (pop_n),
        .word   (word)
    );

    rxp_events u_evt (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .push_req   (push_valid),
        .push_ok    (push_ok),
        .rd_req     (rd_strobe),
        .empty_now  (empty_now),
        .empty_next (empty_next),
        .pop_n      (pop_n),
        .xfer_open  (xfer_open),
        .evt        (evt)
    );

    assign rd_data       = word;
    assign fifo_status   = stat;
    assign more_req      = evt.more_req;
    assign evt_underflow = evt.underflow;
    assign evt_data_req  = evt.data_req;
    assign overflow_seen = evt.overflow;

    p_empty_read_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && empty_now) |-> (rd_data == '0));

    p_drain_clears_dreq_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !flush && !empty_now && empty_next) |=> !evt_data_req);

    p_reset_empties_r10: assert property (@(posedge clk)
        rst |=> (fifo_status[3:0] == 4'd0 && !evt_underflow && !overflow_seen));

endmodule

// File: tb/sim_rx_word_packer.sv
`timescale 1ns/1ps
module sim_rx_word_packer;

    logic        clk = 1'b0;
    logic        rst;
    logic        push_valid, rd_strobe, flush, xfer_open;
    logic [7:0]  push_byte;
    logic [31:0] rd_data;
    logic [7:0]  fifo_status;
    logic        more_req, evt_underflow, evt_data_req, overflow_seen;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] mq[$];

    always #5 clk = ~clk;

    rx_word_packer u0 (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_byte(push_byte),
        .rd_strobe(rd_strobe), .rd_data(rd_data), .fifo_status(fifo_status),
        .flush(flush), .xfer_open(xfer_open), .more_req(more_req),
        .evt_underflow(evt_underflow), .evt_data_req(evt_data_req),
        .overflow_seen(overflow_seen)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] exp_word();
        logic [31:0] w = '0;
        for (int i = 0; i < 4 && i < mq.size(); i++) w[i*8 +: 8] = mq[i];
        return w;
    endfunction

    function automatic logic [7:0] exp_status();
        return {4'h8, 4'((mq.size() + 3) / 4)};
    endfunction

    task automatic push1(input logic [7:0] b);
        push_valid = 1'b1; push_byte = b;
        tick();
        push_valid = 1'b0;
        if (mq.size() < 32) mq.push_back(b);
    endtask

    task automatic read1(input string tag);
        rd_strobe = 1'b1;
        #1;
        check(tag, rd_data, exp_word());
        tick();
        rd_strobe = 1'b0;
        for (int i = 0; i < 4 && mq.size() > 0; i++) void'(mq.pop_front());
    endtask

    task automatic do_reset();
        rst = 1'b1; push_valid = 0; rd_strobe = 0; flush = 0; xfer_open = 0; push_byte = 0;
        tick(); tick();
        rst = 1'b0;
        mq.delete();
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 status", fifo_status, 32'h80);
        check("R1 rd_data", rd_data, 0);
        check("R1 flags", {more_req, evt_underflow, evt_data_req, overflow_seen}, 0);
    endtask

    task automatic t_empty_read();
        xfer_open = 1'b1;
        read1("R2 empty read word");
        check("R2 underflow set", evt_underflow, 1);
        check("R8 no more_req on empty read", more_req, 0);
        tick();
        check("R2 underflow held", evt_underflow, 1);
        xfer_open = 1'b0;
    endtask

    task automatic t_flush();
        push1(8'h11); push1(8'h22);
        flush = 1'b1; push_valid = 1'b1; push_byte = 8'h99;
        tick();
        flush = 1'b0; push_valid = 1'b0;
        mq.delete();
        check("R7 flush status", fifo_status, 32'h80);
        check("R7 underflow cleared", evt_underflow, 0);
        check("R7 data_req unchanged", evt_data_req, 1);
        read1("R7 flush empty read");
    endtask

    task automatic t_lanes();
        do_reset();
        push1(8'hA1);
        check("R4 dreq after push", evt_data_req, 1);
        check("R6 status 1 byte", fifo_status, exp_status());
        read1("R3 one lane");
        check("R5 dreq cleared", evt_data_req, 0);
        push1(8'hA1); push1(8'hB2); push1(8'hC3);
        check("R6 status 3 bytes", fifo_status, exp_status());
        read1("R3 three lanes");
        for (int i = 0; i < 6; i++) push1(8'(8'h40 + i));
        check("R6 status 6 bytes", fifo_status, 32'h82);
        read1("R3 four of six");
        check("R5 dreq held partial", evt_data_req, 1);
        check("R6 status 2 left", fifo_status, 32'h81);
        read1("R3 two lanes");
        check("R5 dreq cleared after drain", evt_data_req, 0);
        for (int i = 0; i < 4; i++) push1(8'(8'hF0 + i));
        check("R6 status 4 bytes", fifo_status, 32'h81);
        read1("R3 four lanes");
    endtask

    task automatic t_more_req();
        xfer_open = 1'b1;
        push1(8'h5A);
        read1("R8 read open");
        check("R8 pulse", more_req, 1);
        tick();
        check("R8 pulse ends", more_req, 0);
        xfer_open = 1'b0;
        push1(8'h5B);
        read1("R8 read closed");
        check("R8 no pulse when closed", more_req, 0);
    endtask

    task automatic t_same_cycle();
        push1(8'h01); push1(8'h02);
        rd_strobe = 1'b1; push_valid = 1'b1; push_byte = 8'h03;
        #1;
        check("R3 read with push", rd_data, exp_word());
        tick();
        rd_strobe = 1'b0; push_valid = 1'b0;
        mq.delete(); mq.push_back(8'h03);
        check("R5 dreq kept by push", evt_data_req, 1);
        check("R6 status after swap", fifo_status, 32'h81);
        read1("R3 pushed byte");
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < 32; i++) push1(8'(i * 7 + 1));
        check("R6 status full", fifo_status, 32'h88);
        check("R9 no overflow yet", overflow_seen, 0);
        push1(8'hEE);
        check("R9 overflow set", overflow_seen, 1);
        rd_strobe = 1'b1; push_valid = 1'b1; push_byte = 8'h55;
        #1;
        check("R9 read at full", rd_data, exp_word());
        tick();
        rd_strobe = 1'b0; push_valid = 1'b0;
        for (int i = 0; i < 4; i++) void'(mq.pop_front());
        mq.push_back(8'h55);
        check("R9 concurrent push accepted", fifo_status, 32'h88);
        for (int i = 0; i < 8; i++) read1("R9 drain");
        check("R9 overflow sticky", overflow_seen, 1);
    endtask

    task automatic t_mid_reset();
        push1(8'h77); push1(8'h78);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        mq.delete();
        check("R10 status", fifo_status, 32'h80);
        check("R10 flags", {evt_underflow, evt_data_req, overflow_seen}, 0);
        read1("R10 empty after reset");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_empty_read();
        t_flush();
        t_lanes();
        t_more_req();
        t_same_cycle();
        t_full();
        t_mid_reset();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule